// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master driven by a CPU through a small register bank. A holding register sits in front of the shift register. Software can therefore queue the next byte while the current one is still shifting out. When a byte finishes and another is waiting, the waiting byte starts on the very next serial half-period, so a stream of bytes leaves with no idle clock between them.

Each byte coming in on MISO is moved into a receive data register when its eighth bit arrives. Two status flags report the state of the block. The transmit-empty flag means the holding register can take a byte. The receive-full flag means a received byte is waiting. Each flag drives a level interrupt output that has its own enable bit. Clock polarity, clock phase and the serial rate are set in a control register. The serial rate is the system clock divided by 2, 4, 8 or 16.

Register map (the bus uses a 2-bit address; reads are combinational and `bus_rd` only marks the side effect of a read):

| Address | Read | Write |
|---|---|---|
| 0 | receive data register | transmit holding register |
| 1 | control register | control register |
| 2 | status register | ignored |
| 3 | zero | ignored |

Control register bits:

| Bit | Meaning |
|---|---|
| 0 | SCK idle level (polarity) |
| 1 | phase (0 = sample on leading edge, 1 = change on leading edge) |
| 3:2 | rate code r (SCK half-period = 2^r system clocks) |
| 4 | transmit interrupt enable |
| 5 | receive interrupt enable |

Status register bits:

| Bit | Meaning |
|---|---|
| 0 | transmit empty |
| 1 | receive full |
| 2 | overrun |

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset the status register reads 0x01 (transmit empty, not full, no overrun), the control register reads 0x00, SCK is low and both interrupt outputs are low.
- R2: A write to address 0 loads the holding register and clears status bit 0 at once. If the shifter is idle, the byte moves into the shifter on the next clock and bit 0 sets again.
- R3: Each byte is shifted out on MOSI most-significant bit first, 8 bits, in all four combinations of control bits 0 and 1. Phase 0 presents a bit before the leading edge; phase 1 changes data on the leading edge. SCK rests at the level of control bit 0 whenever no byte is shifting.
- R4: While a byte is queued, consecutive SCK edges are exactly 2^r system clocks apart across byte boundaries, for every rate code r in 0..3.
- R5: When the eighth bit of an incoming byte is sampled from MISO, the byte moves to the receive data register and status bit 1 sets. A read of address 0 returns that byte.
- R6: Status bit 1 clears only when a read of address 2 made while it was set is followed by a read of address 0. A read of address 0 alone does not clear it. A status read made while the bit was clear does not count.
- R7: A byte that completes while status bit 1 is set does not overwrite the receive data register and sets status bit 2. The clear sequence of R6 clears bit 2 as well.
- R8: `irq_tx` equals status bit 0 AND control bit 4, and `irq_rx` equals status bit 1 AND control bit 5.
- R9: The control register reads back what was written. Writes to address 2 change nothing, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 2 | register address |
| bus_wr | input | 1 | write strobe, one cycle |
| bus_rd | input | 1 | read strobe, marks read side effects |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| irq_tx | output | 1 | transmit-empty interrupt request |
| irq_rx | output | 1 | receive-full interrupt request |

## Verification
A bench slave decodes MOSI on the sampling edge and answers on MISO with an arithmetic byte sequence. The bench sweeps all sixteen combinations of polarity, phase and rate code, each with a three-byte back-to-back stream. This separates errors in bit order, edge choice, idle level and inter-byte spacing from one another. Directed sequences then separate the flag protocol cases:
- a data read with no status read before it;
- a status read made before the byte arrived;
- an overrun from two unread bytes;
- an interrupt output with its enable on and off.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int RATE_W = 2;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              rx_ie;
    logic              tx_ie;
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/spi_edge_timer.sv
module spi_edge_timer #(
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int CW = (1 << RW) - 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = CW'((1 << rate) - 1);
    tick  = run && (cnt_q == lim);
    cnt_d = (run && !tick) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] start_data,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          miso,
  output logic          active,
  output logic          done,
  output logic [DW-1:0] done_byte,
  output logic          sck,
  output logic          mosi
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  logic          active_q, active_d;
  logic [EW-1:0] edge_q, edge_d;
  logic          phase_q, phase_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] rx_q, rx_d;
  logic          mosi_q, mosi_d;
  logic          step, leading, sample;

  always_comb begin
    step      = active_q && tick;
    leading   = !phase_q;
    sample    = leading ^ cpha;
    done      = step && (edge_q == EW'(EDGES - 1));
    done_byte = cpha ? {rx_q[DW-2:0], miso} : rx_q;
  end

  always_comb begin
    active_d = active_q;
    edge_d   = edge_q;
    phase_d  = phase_q;
    tx_d     = tx_q;
    mosi_d   = mosi_q;
    rx_d     = rx_q;
    if (step && sample) rx_d = {rx_q[DW-2:0], miso};
    if (start) begin
      active_d = 1'b1;
      edge_d   = '0;
      phase_d  = 1'b0;
      if (cpha) begin
        tx_d = start_data;
      end else begin
        tx_d   = start_data << 1;
        mosi_d = start_data[DW-1];
      end
    end else if (step) begin
      phase_d = !phase_q;
      edge_d  = edge_q + 1'b1;
      if (done) begin
        active_d = 1'b0;
        edge_d   = '0;
      end
      if ((leading && cpha) || (!leading && !cpha && !done)) begin
        mosi_d = tx_q[DW-1];
        tx_d   = tx_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      edge_q   <= '0;
      phase_q  <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
      mosi_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      edge_q   <= edge_d;
      phase_q  <= phase_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      mosi_q   <= mosi_d;
    end
  end

  assign active = active_q;
  assign sck    = phase_q ^ cpol;
  assign mosi   = mosi_q;
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic rst_meta, rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  ctrl_t         cfg_q, cfg_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          hold_full_q, hold_full_d;
  logic [DW-1:0] rxd_q, rxd_d;
  logic          rx_full_q, rx_full_d;
  logic          ovr_q, ovr_d;
  logic          armed_q, armed_d;

  logic          data_wr, ctrl_wr, data_rd, stat_rd;
  logic          tick, active, last_edge, start;
  logic [DW-1:0] done_byte;
  logic          rx_clear, eff_full, rx_load;

  always_comb begin
    data_wr = bus_wr && (bus_addr == A_DATA);
    ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    data_rd = bus_rd && (bus_addr == A_DATA);
    stat_rd = bus_rd && (bus_addr == A_STAT);
    start   = hold_full_q && (!active || last_edge);
  end

  spi_edge_timer #(.RW(RATE_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_int),
    .run   (active),
    .rate  (cfg_q.rate),
    .tick  (tick)
  );

  spi_shift_engine #(.DW(DW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_int),
    .tick       (tick),
    .start      (start),
    .start_data (hold_q),
    .cpol       (cfg_q.cpol),
    .cpha       (cfg_q.cpha),
    .miso       (miso),
    .active     (active),
    .done       (last_edge),
    .done_byte  (done_byte),
    .sck        (sck),
    .mosi       (mosi)
  );

  always_comb begin
    cfg_d       = ctrl_wr ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : cfg_q;
    hold_d      = data_wr ? bus_wdata : hold_q;
    hold_full_d = hold_full_q;
    if (start)   hold_full_d = 1'b0;
    if (data_wr) hold_full_d = 1'b1;
  end

  always_comb begin
    rx_clear  = data_rd && armed_q;
    eff_full  = rx_full_q && !rx_clear;
    rx_load   = last_edge && !eff_full;
    rxd_d     = rx_load ? done_byte : rxd_q;
    rx_full_d = rx_load ? 1'b1 : eff_full;
    ovr_d     = (last_edge && eff_full) ? 1'b1 : (rx_clear ? 1'b0 : ovr_q);
    armed_d   = armed_q;
    if (rx_clear)     armed_d = 1'b0;
    else if (stat_rd) armed_d = rx_full_q;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      cfg_q       <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      rxd_q       <= '0;
      rx_full_q   <= 1'b0;
      ovr_q       <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      cfg_q       <= cfg_d;
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      rxd_q       <= rxd_d;
      rx_full_q   <= rx_full_d;
      ovr_q       <= ovr_d;
      armed_q     <= armed_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rxd_q;
      A_CTRL:  bus_rdata = DW'(cfg_q);
      A_STAT:  bus_rdata = DW'({ovr_q, rx_full_q, !hold_full_q});
      default: bus_rdata = '0;
    endcase
    irq_tx = !hold_full_q && cfg_q.tx_ie;
    irq_rx = rx_full_q && cfg_q.rx_ie;
  end
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cpol,
  input logic active,
  input logic hold_full,
  input logic rx_full,
  input logic ovr,
  input logic armed,
  input logic done,
  input logic data_rd
);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sck == cpol));

  // R2
  load_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !active) |=> active);

  // R4
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hold_full) |=> active);

  // R5
  rx_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(done));

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> ($past(armed) && $past(data_rd)));

  // R7
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(done) && $past(rx_full)));
endmodule

bind spi_dbuf_master spi_dbuf_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int),
  .sck       (sck),
  .cpol      (cfg_q.cpol),
  .active    (active),
  .hold_full (hold_full_q),
  .rx_full   (rx_full_q),
  .ovr       (ovr_q),
  .armed     (armed_q),
  .done      (last_edge),
  .data_rd   (data_rd)
);

// File: tb/spi_dbuf_master_test.sv
`timescale 1ns/1ps
module spi_dbuf_master_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       sck, mosi, miso, irq_tx, irq_rx;

  always #5 clk = ~clk;

  spi_dbuf_master uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  function automatic logic [7:0] slv(input int i);
    return 8'(i * 29 + 92);
  endfunction

  function automatic logic [7:0] wbyte(input int c, input int k);
    return 8'(c * 53 + k * 91 + 7);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench slave and line monitor
  logic m_cpol = 0, m_cpha = 0, mon_en = 0, mon_rst = 1;
  int   m_half = 1;
  int   cyc_n = 0, sidx = 0, sbit = 0, mcnt = 0, mn = 0;
  int   last_e = 0, have_e = 0, gap_err = 0;
  logic [7:0] mbyte = 0;
  logic [7:0] mlog [0:3];
  logic sck_prev = 0;
  logic lead;
  logic [7:0] scur;

  always_comb begin
    scur = slv(sidx);
    miso = scur[7 - sbit];
  end

  always @(negedge clk) begin
    cyc_n++;
    if (mon_rst) begin
      sidx = 0; sbit = 0; mcnt = 0; mn = 0; have_e = 0; gap_err = 0; mbyte = 0;
    end else if (mon_en && (sck !== sck_prev)) begin
      lead = (sck_prev == m_cpol);
      if (have_e != 0 && (cyc_n - last_e) != m_half) gap_err++;
      last_e = cyc_n;
      have_e = 1;
      if (lead ^ m_cpha) begin
        mbyte = {mbyte[6:0], mosi};
        mcnt++;
        if (mcnt == 8) begin
          if (mn < 4) mlog[mn] = mbyte;
          mn++;
          mcnt = 0;
        end
      end
      if (!lead) begin
        sbit++;
        if (sbit == 8) begin sbit = 0; sidx++; end
      end
    end
    sck_prev = sck;
  end

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_stat(input int bitn, input logic val);
    logic [7:0] s;
    peek(2'd2, s);
    while (s[bitn] !== val) begin
      @(negedge clk);
      peek(2'd2, s);
    end
  endtask

  task automatic mon_restart();
    @(negedge clk); mon_rst = 1;
    @(negedge clk); mon_rst = 0; mon_en = 1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int cnt0;
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(2'd2, s); chk("R1 status", s, 8'h01);
    peek(2'd1, s); chk("R1 control", s, 8'h00);
    chk("R1 sck", sck, 0);
    chk("R1 irq_tx", irq_tx, 0);
    chk("R1 irq_rx", irq_rx, 0);

    // sweep: all polarity/phase/rate combinations, 3 back-to-back bytes
    for (int c = 0; c < 16; c++) begin
      m_cpol = c[0]; m_cpha = c[1]; m_half = 1 << (c >> 2);
      mon_en = 0;
      cpu_write(2'd1, 8'(c));
      mon_restart();
      chk($sformatf("R3 idle level cfg%0d", c), sck, m_cpol);
      cpu_write(2'd0, wbyte(c, 0));
      @(negedge clk); wait_stat(0, 1'b1);
      cpu_write(2'd0, wbyte(c, 1));
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); wait_stat(1, 1'b1);
        cpu_read(2'd2, s);
        cpu_read(2'd0, d);
        chk($sformatf("R5 rx byte cfg%0d k%0d", c, k), d, slv(k));
        if (k == 0) begin
          wait_stat(0, 1'b1);
          cpu_write(2'd0, wbyte(c, 2));
        end
      end
      while (mn < 3) @(negedge clk);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 3; k++)
        chk($sformatf("R3 mosi byte cfg%0d k%0d", c, k), mlog[k], wbyte(c, k));
      chk($sformatf("R4 edge spacing cfg%0d", c), gap_err, 0);
      chk($sformatf("R3 idle after cfg%0d", c), sck, m_cpol);
      peek(2'd2, s); chk($sformatf("R6 status clean cfg%0d", c), s, 8'h01);
    end

    // directed: fastest rate, mode 0, transmit interrupt enabled
    m_cpol = 0; m_cpha = 0; m_half = 1; mon_en = 0;
    cpu_write(2'd1, 8'h10);
    mon_restart();
    chk("R8 irq_tx enabled idle", irq_tx, 1);
    cpu_write(2'd0, 8'h96);
    peek(2'd2, s); chk("R2 tx empty cleared", s[0], 0);
    chk("R8 irq_tx follows", irq_tx, 0);
    @(negedge clk);
    peek(2'd2, s); chk("R2 tx empty set on move", s[0], 1);
    chk("R8 irq_tx back", irq_tx, 1);
    wait_stat(1, 1'b1);
    chk("R8 irq_rx gated off", irq_rx, 0);
    cpu_read(2'd0, d); chk("R5 data read", d, slv(0));
    peek(2'd2, s); chk("R6 data read alone keeps full", s[1], 1);
    cpu_read(2'd2, s);
    cpu_read(2'd0, d);
    peek(2'd2, s); chk("R6 sequence clears", s[1], 0);

    // R6: status read while empty does not arm
    cpu_write(2'd1, 8'h20);
    cpu_read(2'd2, s);
    cpu_write(2'd0, 8'h5A);
    @(negedge clk); wait_stat(1, 1'b1);
    chk("R8 irq_rx enabled", irq_rx, 1);
    cpu_read(2'd0, d); chk("R5 second byte", d, slv(1));
    peek(2'd2, s); chk("R6 early status read ignored", s[1], 1);
    cpu_read(2'd2, s);
    cpu_read(2'd0, d);
    peek(2'd2, s); chk("R6 cleared after sequence", s[1], 0);
    chk("R8 irq_rx drops", irq_rx, 0);

    // R7 overrun
    cpu_write(2'd0, 8'hC3);
    @(negedge clk); wait_stat(0, 1'b1);
    cpu_write(2'd0, 8'h3C);
    @(negedge clk); wait_stat(2, 1'b1);
    cpu_read(2'd0, d); chk("R7 first byte kept", d, slv(2));
    peek(2'd2, s); chk("R7 status with overrun", s, 8'h07);
    cpu_read(2'd2, s);
    cpu_read(2'd0, d);
    peek(2'd2, s); chk("R7 overrun cleared", s, 8'h01);

    // R9 control readback and ignored writes
    mon_en = 0;
    cpu_write(2'd1, 8'h2D);
    peek(2'd1, s); chk("R9 control readback", s, 8'h2D);
    cpu_write(2'd2, 8'hFF);
    peek(2'd2, s); chk("R9 status write ignored", s, 8'h01);
    peek(2'd3, s); chk("R9 unused address", s, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule